// File: doc/BRIEF.md
# Converter Power-Up Register Sequencer

This block sits on the host side of a multi-channel data converter and takes it from cold power-up to a configured, calibrated state with no software involvement. After a start request it counts a power-on delay and drives an active-high hardware reset pulse to the converter. It then holds off a settling window before it enables the serial port. After that it replays a fixed script of byte-wide register writes through a request/acknowledge port that feeds an external serial shifting engine.

The script is built in logic, not loaded from a file. It opens with a software reset. Every group of writes begins with three page-select writes (addresses 11h, 12h, 13h), and the group's own writes follow. One entry in the script is a timed pause: it lets the converter calibrate between the write that enables calibration and the write that disables it. A parameter chooses between two variants: plain bypass operation, or interleaved operation with averaging. All wait lengths are parameters counted in reference clock cycles, and their defaults are derived from a clock-frequency parameter.

The state machine has seven states. IDLE and FINISH go to POWER on start. POWER, PULSE and SETTLE each leave when their timer expires: POWER goes to PULSE, PULSE goes to SETTLE and SETTLE goes to ISSUE. ISSUE stays while it waits for an acknowledge, and advances the script pointer on each one. It goes to PAUSE at the pause entry and to FINISH after the final write is acknowledged. PAUSE returns to ISSUE when its timer expires.

Top module: `cvt_boot_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until the first start, `busy_o`, `done_o`, `cvt_reset_o`, `spi_en_o` and `wr_req_o` are all 0.
- R2: `cvt_reset_o` rises no sooner than POR_CYC clock cycles after the cycle in which `start_i` is accepted.
- R3: `cvt_reset_o` is high for exactly RST_CYC consecutive cycles per run, and only while `busy_o` is high.
- R4: `spi_en_o` and `wr_req_o` stay low during the reset pulse and for at least POST_RST_CYC cycles after it falls. `wr_req_o` is only high while `spi_en_o` is high.
- R5: Once raised, `wr_req_o` stays high with `wr_addr_o`/`wr_data_o` unchanged until `wr_ack_i` is seen. Each acknowledge consumes exactly one write.
- R6: The first write of every run is address 00h, data 81h (software reset).
- R7: In bypass mode (INTERLEAVE=0) the 35 writes follow this order: 00h=81h. Digital page (11h=00h, 12h=01h, 13h=00h): ABh=01h, ACh=01h, ADh=08h, AEh=08h, 64h=02h. Link page (11h=00h, 12h=60h, 13h=00h): 26h=0Fh, 20h=80h. Converter-core pages (11h=FFh, 12h=00h, 13h=00h): D5h=08h, pause, D5h=00h, 2Ah=00h, CFh=50h. Channel pages (11h=00h, 12h=1Eh, 13h=00h): 2Dh=02h. Digital page: 8Ch=02h, B7h=01h, B7h=00h. Analog page (11h=00h, 12h=00h, 13h=01h): 6Ah=02h.
- R8: Between the acknowledge of D5h=08h and the request of D5h=00h, at least CAL_CYC cycles pass.
- R9: The trim-load strobe is B7h=01h followed immediately by B7h=00h, directly after 8Ch=02h.
- R10: The last write is 6Ah=02h, preceded by the analog page select 13h=01h. After it is acknowledged, `done_o` rises, and `busy_o`, `spi_en_o` and `wr_req_o` fall.
- R11: With INTERLEAVE=1 the script is the R7 list with A5h=03h and A6h=20h inserted directly after the first digital page select, and with ABh and ACh written as 03h (37 writes).
- R12: A start request while `busy_o` is high is ignored. The run continues unchanged, and no second reset pulse is produced.
- R13: `done_o` and `busy_o` are never high together. `done_o` stays high until a start request, and one cycle later `done_o` is 0 and `busy_o` is 1. A new run then repeats the whole script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all waits are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| start_i | input | 1 | Start request, sampled in IDLE and FINISH |
| wr_ack_i | input | 1 | Serial engine has accepted the current write |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Script completed; held until the next start |
| cvt_reset_o | output | 1 | Active-high hardware reset to the converter |
| spi_en_o | output | 1 | Serial port enable, high only while the script runs |
| wr_req_o | output | 1 | Write request to the serial engine |
| wr_addr_o | output | 8 | Register address of the pending write |
| wr_data_o | output | 8 | Register data of the pending write |

## Verification
The hardest situation to reach is a start request that lands in the middle of a run and must leave no trace. The bench drives one as soon as the serial port opens. It then checks that no second reset pulse appears, and that the whole logged write list still matches the expected order one for one. The calibration pause is timed from the acknowledge of the enabling write to the first request of the disabling write. The serial engine model adds a fixed acknowledge latency, so every write is held for several cycles and the hold-until-acknowledge rule is exercised at every step.

// File: rtl/cvt_boot_pkg.sv
package cvt_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWER,
        ST_PULSE,
        ST_SETTLE,
        ST_ISSUE,
        ST_PAUSE,
        ST_FINISH
    } boot_state_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_PAUSE = 1'b1
    } step_op_e;

    typedef struct packed {
        step_op_e   op;
        logic [7:0] addr;
        logic [7:0] data;
    } step_t;

    localparam int BASE_STEPS  = 36;
    localparam int EXTRA_STEPS = 2;

    function automatic step_t mk_wr(input logic [7:0] a, input logic [7:0] d);
        step_t s;
        s.op   = OP_WRITE;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

    function automatic step_t mk_pause();
        step_t s;
        s.op   = OP_PAUSE;
        s.addr = 8'h00;
        s.data = 8'h00;
        return s;
    endfunction

endpackage

// File: rtl/cvt_boot_rom.sv
module cvt_boot_rom
    import cvt_boot_pkg::*;
#(
    parameter bit INTERLEAVE = 1'b0,
    parameter int IW         = 6
) (
    input  logic [IW-1:0] idx_i,
    output step_t         step_o
);

    function automatic step_t base_step(input int k);
        step_t s;
        case (k)
            0:  s = mk_wr(8'h00, 8'h81);
            1:  s = mk_wr(8'h11, 8'h00);
            2:  s = mk_wr(8'h12, 8'h01);
            3:  s = mk_wr(8'h13, 8'h00);
            4:  s = mk_wr(8'hAB, 8'h01);
            5:  s = mk_wr(8'hAC, 8'h01);
            6:  s = mk_wr(8'hAD, 8'h08);
            7:  s = mk_wr(8'hAE, 8'h08);
            8:  s = mk_wr(8'h64, 8'h02);
            9:  s = mk_wr(8'h11, 8'h00);
            10: s = mk_wr(8'h12, 8'h60);
            11: s = mk_wr(8'h13, 8'h00);
            12: s = mk_wr(8'h26, 8'h0F);
            13: s = mk_wr(8'h20, 8'h80);
            14: s = mk_wr(8'h11, 8'hFF);
            15: s = mk_wr(8'h12, 8'h00);
            16: s = mk_wr(8'h13, 8'h00);
            17: s = mk_wr(8'hD5, 8'h08);
            18: s = mk_pause();
            19: s = mk_wr(8'hD5, 8'h00);
            20: s = mk_wr(8'h2A, 8'h00);
            21: s = mk_wr(8'hCF, 8'h50);
            22: s = mk_wr(8'h11, 8'h00);
            23: s = mk_wr(8'h12, 8'h1E);
            24: s = mk_wr(8'h13, 8'h00);
            25: s = mk_wr(8'h2D, 8'h02);
            26: s = mk_wr(8'h11, 8'h00);
            27: s = mk_wr(8'h12, 8'h01);
            28: s = mk_wr(8'h13, 8'h00);
            29: s = mk_wr(8'h8C, 8'h02);
            30: s = mk_wr(8'hB7, 8'h01);
            31: s = mk_wr(8'hB7, 8'h00);
            32: s = mk_wr(8'h11, 8'h00);
            33: s = mk_wr(8'h12, 8'h00);
            34: s = mk_wr(8'h13, 8'h01);
            35: s = mk_wr(8'h6A, 8'h02);
            default: s = mk_wr(8'h6A, 8'h02);
        endcase
        return s;
    endfunction

    generate
        if (INTERLEAVE) begin : g_interleave
            always_comb begin
                int k;
                k = int'(idx_i);
                if (k < 4) begin
                    step_o = base_step(k);
                end else if (k == 4) begin
                    step_o = mk_wr(8'hA5, 8'h03);
                end else if (k == 5) begin
                    step_o = mk_wr(8'hA6, 8'h20);
                end else begin
                    step_o = base_step(k - EXTRA_STEPS);
                    if (step_o.addr == 8'hAB || step_o.addr == 8'hAC) begin
                        step_o.data = 8'h03;
                    end
                end
            end
        end else begin : g_bypass
            always_comb begin
                step_o = base_step(int'(idx_i));
            end
        end
    endgenerate

endmodule

// File: rtl/cvt_boot_timer.sv
module cvt_boot_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] value_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cvt_boot_seq.sv
module cvt_boot_seq
    import cvt_boot_pkg::*;
#(
    parameter int CLK_HZ       = 125_000_000,
    parameter bit INTERLEAVE   = 1'b0,
    parameter int POR_CYC      = CLK_HZ / 1_000 + 1,
    parameter int RST_CYC      = CLK_HZ / 100_000_000 + 1,
    parameter int POST_RST_CYC = CLK_HZ / 10_000 + 1,
    parameter int CAL_CYC      = CLK_HZ / 500 + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wr_ack_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       cvt_reset_o,
    output logic       spi_en_o,
    output logic       wr_req_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);

    localparam int SCRIPT_LEN = INTERLEAVE ? (BASE_STEPS + EXTRA_STEPS) : BASE_STEPS;
    localparam int IW         = $clog2(SCRIPT_LEN);
    localparam int MAX_A      = (POR_CYC > RST_CYC) ? POR_CYC : RST_CYC;
    localparam int MAX_B      = (POST_RST_CYC > CAL_CYC) ? POST_RST_CYC : CAL_CYC;
    localparam int MAX_WAIT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW         = $clog2(MAX_WAIT + 1);

    localparam logic [TW-1:0] POR_LD  = TW'(POR_CYC - 1);
    localparam logic [TW-1:0] RST_LD  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] POST_LD = TW'(POST_RST_CYC - 1);
    localparam logic [TW-1:0] CAL_LD  = TW'(CAL_CYC - 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(SCRIPT_LEN - 1);

    boot_state_e   state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          idx_inc, idx_clr;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_value;
    step_t         step;
    logic          last_step;

    cvt_boot_rom #(
        .INTERLEAVE (INTERLEAVE),
        .IW         (IW)
    ) u_rom (
        .idx_i  (idx_q),
        .step_o (step)
    );

    cvt_boot_timer #(
        .TW (TW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_value),
        .expired_o (tmr_expired)
    );

    assign last_step = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // script pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_clr) begin
            idx_q <= '0;
        end else if (idx_inc) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // next state, timer loads and pointer moves
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_value = '0;
        idx_inc   = 1'b0;
        idx_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start_i) begin
                    state_d   = ST_POWER;
                    tmr_load  = 1'b1;
                    tmr_value = POR_LD;
                    idx_clr   = 1'b1;
                end
            end
            ST_POWER: begin
                if (tmr_expired) begin
                    state_d   = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_value = RST_LD;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    state_d   = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_value = POST_LD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (step.op == OP_PAUSE) begin
                    state_d   = ST_PAUSE;
                    tmr_load  = 1'b1;
                    tmr_value = CAL_LD;
                    idx_inc   = 1'b1;
                end else if (wr_ack_i) begin
                    if (last_step) begin
                        state_d = ST_FINISH;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (tmr_expired) begin
                    state_d = ST_ISSUE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy_o      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done_o      = (state_q == ST_FINISH);
        cvt_reset_o = (state_q == ST_PULSE);
        spi_en_o    = (state_q == ST_ISSUE) || (state_q == ST_PAUSE);
        wr_req_o    = (state_q == ST_ISSUE) && (step.op == OP_WRITE);
        wr_addr_o   = wr_req_o ? step.addr : 8'h00;
        wr_data_o   = wr_req_o ? step.data : 8'h00;
    end

endmodule

// File: rtl/cvt_boot_seq_chk.sv
module cvt_boot_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       wr_ack_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       cvt_reset_o,
    input logic       spi_en_o,
    input logic       wr_req_o,
    input logic [7:0] wr_addr_o,
    input logic [7:0] wr_data_o
);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !done_o && !cvt_reset_o && !wr_req_o); // R1

    AST_RESET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_reset_o |-> busy_o); // R3

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_reset_o |-> !spi_en_o && !wr_req_o); // R4

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> spi_en_o); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R5

    AST_FINISH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_req_o && !spi_en_o && !cvt_reset_o); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> busy_o); // R12

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R13

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o); // R13

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && start_i |=> !done_o && busy_o); // R13

endmodule

bind cvt_boot_seq cvt_boot_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wr_ack_i    (wr_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cvt_reset_o (cvt_reset_o),
    .spi_en_o    (spi_en_o),
    .wr_req_o    (wr_req_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o)
);

// File: tb/cvt_boot_seq_tb.sv
module cvt_boot_seq_tb;

    localparam int POR  = 40;
    localparam int RSTW = 3;
    localparam int POST = 25;
    localparam int CAL  = 60;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic       start_v [2];
    logic       ack_v   [2];
    logic       busy_v  [2];
    logic       done_v  [2];
    logic       rst_v   [2];
    logic       en_v    [2];
    logic       req_v   [2];
    logic [7:0] addr_v  [2];
    logic [7:0] data_v  [2];

    logic a_start, a_ack, a_busy, a_done, a_rst, a_en, a_req;
    logic b_start, b_ack, b_busy, b_done, b_rst, b_en, b_req;
    logic [7:0] a_addr, a_data, b_addr, b_data;

    assign a_start = start_v[0];
    assign a_ack   = ack_v[0];
    assign b_start = start_v[1];
    assign b_ack   = ack_v[1];
    assign busy_v[0] = a_busy; assign busy_v[1] = b_busy;
    assign done_v[0] = a_done; assign done_v[1] = b_done;
    assign rst_v[0]  = a_rst;  assign rst_v[1]  = b_rst;
    assign en_v[0]   = a_en;   assign en_v[1]   = b_en;
    assign req_v[0]  = a_req;  assign req_v[1]  = b_req;
    assign addr_v[0] = a_addr; assign addr_v[1] = b_addr;
    assign data_v[0] = a_data; assign data_v[1] = b_data;

    cvt_boot_seq #(
        .INTERLEAVE (1'b0), .POR_CYC (POR), .RST_CYC (RSTW),
        .POST_RST_CYC (POST), .CAL_CYC (CAL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (a_start), .wr_ack_i (a_ack),
        .busy_o (a_busy), .done_o (a_done), .cvt_reset_o (a_rst), .spi_en_o (a_en),
        .wr_req_o (a_req), .wr_addr_o (a_addr), .wr_data_o (a_data)
    );

    cvt_boot_seq #(
        .INTERLEAVE (1'b1), .POR_CYC (POR), .RST_CYC (RSTW),
        .POST_RST_CYC (POST), .CAL_CYC (CAL)
    ) u_dut_il (
        .clk (clk), .rst_n (rst_n), .start_i (b_start), .wr_ack_i (b_ack),
        .busy_o (b_busy), .done_o (b_done), .cvt_reset_o (b_rst), .spi_en_o (b_en),
        .wr_req_o (b_req), .wr_addr_o (b_addr), .wr_data_o (b_data)
    );

    int total = 0;
    int bad = 0;

    logic [15:0] log_w [2][64];
    int n_log [2];
    int rise_c [2], fall_c [2], en_c [2], hi_cnt [2], wcnt [2];
    int cal_ack_c [2], cal_req_c [2];
    bit prev_rst [2], seen_en [2];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_mon(input int k);
        n_log[k] = 0; rise_c[k] = -1; fall_c[k] = -1; en_c[k] = -1;
        hi_cnt[k] = 0; wcnt[k] = 0; cal_ack_c[k] = -1; cal_req_c[k] = -1;
        seen_en[k] = 1'b0;
    endtask

    // serial engine model and port monitor, one process for both instances
    initial begin
        for (int k = 0; k < 2; k++) begin
            ack_v[k] = 1'b0; start_v[k] = 1'b0; prev_rst[k] = 1'b0;
            clear_mon(k);
        end
        forever begin
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                if (rst_v[k] && !prev_rst[k]) rise_c[k] = cyc;
                if (!rst_v[k] && prev_rst[k]) fall_c[k] = cyc;
                if (rst_v[k]) hi_cnt[k]++;
                prev_rst[k] = rst_v[k];
                if (en_v[k] && !seen_en[k]) begin
                    seen_en[k] = 1'b1;
                    en_c[k] = cyc;
                end
                if (ack_v[k]) begin
                    ack_v[k] = 1'b0;
                end else if (req_v[k]) begin
                    if (addr_v[k] == 8'hD5 && data_v[k] == 8'h00 && cal_req_c[k] < 0)
                        cal_req_c[k] = cyc;
                    if (wcnt[k] == LAT) begin
                        ack_v[k] = 1'b1;
                        wcnt[k] = 0;
                        if (n_log[k] < 64) log_w[k][n_log[k]] = {addr_v[k], data_v[k]};
                        n_log[k]++;
                        if (addr_v[k] == 8'hD5 && data_v[k] == 8'h08) cal_ack_c[k] = cyc;
                    end else begin
                        wcnt[k]++;
                    end
                end
            end
        end
    end

    function automatic logic [15:0] base_w(input int j);
        logic [15:0] w;
        case (j)
            0: w = 16'h0081;
            1: w = 16'h1100; 2: w = 16'h1201; 3: w = 16'h1300;
            4: w = 16'hAB01; 5: w = 16'hAC01; 6: w = 16'hAD08; 7: w = 16'hAE08; 8: w = 16'h6402;
            9: w = 16'h1100; 10: w = 16'h1260; 11: w = 16'h1300; 12: w = 16'h260F; 13: w = 16'h2080;
            14: w = 16'h11FF; 15: w = 16'h1200; 16: w = 16'h1300; 17: w = 16'hD508;
            18: w = 16'hD500; 19: w = 16'h2A00; 20: w = 16'hCF50;
            21: w = 16'h1100; 22: w = 16'h121E; 23: w = 16'h1300; 24: w = 16'h2D02;
            25: w = 16'h1100; 26: w = 16'h1201; 27: w = 16'h1300;
            28: w = 16'h8C02; 29: w = 16'hB701; 30: w = 16'hB700;
            31: w = 16'h1100; 32: w = 16'h1200; 33: w = 16'h1301; 34: w = 16'h6A02;
            default: w = 16'hFFFF;
        endcase
        return w;
    endfunction

    function automatic logic [15:0] exp_w(input int k, input int i);
        logic [15:0] w;
        if (k == 0 || i < 4) return base_w(i);
        if (i == 4) return 16'hA503;
        if (i == 5) return 16'hA620;
        w = base_w(i - 2);
        if (w[15:8] == 8'hAB || w[15:8] == 8'hAC) w[7:0] = 8'h03;
        return w;
    endfunction

    task automatic pulse_start(input int k);
        @(negedge clk);
        start_v[k] = 1'b1;
        @(negedge clk);
        start_v[k] = 1'b0;
    endtask

    task automatic wait_done(input int k);
        int n;
        n = 0;
        while (!done_v[k] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_v[k], "R10", "done reached", int'(done_v[k]), 1);
    endtask

    // timing, contents and ordering of one logged run
    task automatic check_run(input int k, input int start_c);
        int nexp, mism, p8c;
        string rq;
        nexp = (k == 0) ? 35 : 37;
        rq = (k == 0) ? "R7" : "R11";
        chk(rise_c[k] - start_c >= POR && rise_c[k] - start_c <= POR + 2,
            "R2", "start to reset rise", rise_c[k] - start_c, POR + 1);
        chk(hi_cnt[k] == RSTW, "R3", "reset pulse width", hi_cnt[k], RSTW);
        chk(en_c[k] - fall_c[k] >= POST && en_c[k] - fall_c[k] <= POST + 1,
            "R4", "reset fall to serial enable", en_c[k] - fall_c[k], POST);
        chk(cal_req_c[k] - cal_ack_c[k] >= CAL && cal_req_c[k] - cal_ack_c[k] <= CAL + 3,
            "R8", "calibration pause", cal_req_c[k] - cal_ack_c[k], CAL + 2);
        chk(n_log[k] == nexp, rq, "write count", n_log[k], nexp);
        chk(log_w[k][0] == 16'h0081, "R6", "first write", int'(log_w[k][0]), 16'h0081);
        mism = -1;
        for (int i = 0; i < nexp && i < 64; i++)
            if (mism < 0 && log_w[k][i] !== exp_w(k, i)) mism = i;
        chk(mism < 0, rq, "write list first mismatch index", mism, -1);
        p8c = -1;
        for (int i = 0; i < n_log[k] - 2 && i < 62; i++)
            if (p8c < 0 && log_w[k][i] == 16'h8C02) p8c = i;
        chk(p8c >= 0 && log_w[k][p8c+1] == 16'hB701 && log_w[k][p8c+2] == 16'hB700,
            "R9", "trim strobe after 8Ch", p8c, nexp - 7);
        chk(n_log[k] >= 2 && log_w[k][n_log[k]-1] == 16'h6A02 && log_w[k][n_log[k]-2] == 16'h1301,
            "R10", "closing analog page write", int'(log_w[k][n_log[k]-1]), 16'h6A02);
        chk(!busy_v[k] && !en_v[k] && !req_v[k], "R10", "quiet after finish",
            int'(busy_v[k]) + int'(en_v[k]) + int'(req_v[k]), 0);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk(!a_busy && !a_done && !a_rst && !a_en && !a_req, "R1", "outputs in reset",
            int'(a_busy) + int'(a_done) + int'(a_rst) + int'(a_en) + int'(a_req), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!a_busy && !a_done && !a_rst && !a_en && !a_req && !b_busy && !b_done,
            "R1", "outputs idle after reset",
            int'(a_busy) + int'(a_done) + int'(a_rst) + int'(b_busy) + int'(b_done), 0);
    endtask

    task automatic t_bypass_with_stray_start();
        int sc, n;
        clear_mon(0);
        @(negedge clk);
        sc = cyc;
        start_v[0] = 1'b1;
        @(negedge clk);
        start_v[0] = 1'b0;
        n = 0;
        while (!a_en && n < 2000) begin
            @(negedge clk);
            n++;
        end
        pulse_start(0);
        @(negedge clk);
        chk(a_busy && !a_done, "R12", "busy kept after stray start", int'(a_busy), 1);
        wait_done(0);
        chk(hi_cnt[0] == RSTW, "R12", "no second reset pulse", hi_cnt[0], RSTW);
        check_run(0, sc);
    endtask

    task automatic t_done_hold_restart();
        int sc;
        repeat (30) @(negedge clk);
        chk(a_done && !a_busy, "R13", "done held while idle", int'(a_done), 1);
        clear_mon(0);
        @(negedge clk);
        sc = cyc;
        start_v[0] = 1'b1;
        @(negedge clk);
        start_v[0] = 1'b0;
        chk(!a_done && a_busy, "R13", "start clears done, sets busy",
            int'(a_done) * 2 + int'(a_busy), 1);
        wait_done(0);
        check_run(0, sc);
    endtask

    task automatic t_interleave();
        int sc;
        clear_mon(1);
        @(negedge clk);
        sc = cyc;
        start_v[1] = 1'b1;
        @(negedge clk);
        start_v[1] = 1'b0;
        wait_done(1);
        check_run(1, sc);
        chk(log_w[1][4] == 16'hA503 && log_w[1][5] == 16'hA620, "R11", "averaging writes",
            int'(log_w[1][4]), 16'hA503);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset_state();
        t_bypass_with_stray_start();
        t_done_hold_restart();
        t_interleave();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule